// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces horizontal sync, vertical sync and display-enable for a raster display. Software programs the timing through a small register write port. One pixel counter runs from zero to the programmed frame length and wraps at the end of each frame. A second counter, the horizontal position, counts from the start of each hsync pulse.

Vertical sync length and the vertical display window are set as offsets in pixel clocks from frame start, not as line numbers. A mode with V lines of H pixels therefore programs a frame length of V*H. The horizontal display window is set in pixels, measured from the start of hsync.

Every timing register is copied into an active set only when a frame begins. A frame never mixes old and new timing. Polarity, the underflow colour and the border colour are used live. The block also drives the pixel output from an input stream, shows a fill colour when that stream underflows, and keeps a line counter and a frame counter.

Top module: `frame_timing_gen`

## Requirements
- R1: Register 0 holds the line period in bits [15:0] and the hsync width in bits [31:16]. While running, hsync is active for the first width pixels of every line, and a line lasts exactly period pixels.
- R2: Register 2 holds the frame length in pixel clocks and register 3 the vsync length in pixel clocks. vsync is active for the first vsync-length pixel clocks of each frame. A frame lasts exactly frame-length clocks.
- R3: Display-enable is high only where both windows hold. The horizontal position must be between bits [15:0] and bits [31:16] of register 1, inclusive. The frame offset must be between register 4 and register 5, inclusive.
- R4: Register 6 sets the sync polarity. Bit 0 set makes hsync active-low and bit 1 set makes vsync active-low; a clear bit gives active-high. The setting takes effect without waiting for a frame boundary.
- R5: When display-enable is high, the pixel output is the input pixel if the valid input is high. If valid is low, it is the underflow colour from register 7, which resets to 0xff. When display-enable is low, the pixel output is the border colour from register 8, which resets to 0.
- R6: Writing 1 to bit 0 of register 9 starts a frame at offset 0. Writing 0 lets the current frame finish, after which the generator idles. While idle, display-enable stays low and both syncs sit at their inactive level.
- R7: The vblank output pulses for one cycle, at the same time as the last pixel clock of each frame.
- R8: A timing register written during a frame does not change that frame. The new value applies from the next frame start.
- R9: When bit 0 of register 10 is set, the line counter is 0 on the first line of a frame and increases by one at each later line start. When the bit is clear, the line counter holds.
- R10: When bit 1 of register 10 is set, the 16-bit frame counter increases by one at each frame end and wraps. When the bit is clear, the frame counter holds.
- R11: After reset, the block is idle. hsync, vsync, display-enable and vblank are low, both counters are 0 and the pixel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write value |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_data | input | 24 | Input pixel colour |
| hsync | output | 1 | Horizontal sync, polarity per register 6 |
| vsync | output | 1 | Vertical sync, polarity per register 6 |
| de | output | 1 | Display enable |
| pix_out | output | 24 | Output pixel colour |
| vblank | output | 1 | One-cycle pulse on the last pixel of a frame |
| line_cnt | output | 16 | Current line number |
| frame_cnt | output | 16 | Completed frame count |

## Verification
The bench derives register values from two distinct display modes, each given as totals, display sizes and sync positions. It compares every pixel clock of a frame with its own position model. It also checks frame-level totals: hsync cycles equal width times lines, vsync cycles equal vsync length, and display-enable cycles equal display width times display height. The totals would expose an off-by-one at a window edge even if the position model shared it.

The pixel input is tried three ways: valid with data, starved with the default fill colour, and starved after the fill and border colours are reprogrammed. These runs separate the data path, the underflow path and the border path. Further runs cover:
- rewriting the timing in mid-frame;
- inverting polarity;
- disabling the counters;
- stopping in mid-frame;
- restarting from idle with a different mode.

These show shadowing, live polarity, counter hold and the finish-the-frame stop.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  parameter int H_W    = 16;
  parameter int F_W    = 32;
  parameter int COL_W  = 24;
  parameter int CNT_W  = 16;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic [H_W-1:0] hper;
    logic [H_W-1:0] hpw;
    logic [H_W-1:0] hstart;
    logic [H_W-1:0] hend;
    logic [F_W-1:0] vper;
    logic [F_W-1:0] vlen;
    logic [F_W-1:0] vstart;
    logic [F_W-1:0] vend;
  } timing_t;

  localparam logic [ADDR_W-1:0] RA_HCTL   = 4'd0;
  localparam logic [ADDR_W-1:0] RA_HWIN   = 4'd1;
  localparam logic [ADDR_W-1:0] RA_VPER   = 4'd2;
  localparam logic [ADDR_W-1:0] RA_VLEN   = 4'd3;
  localparam logic [ADDR_W-1:0] RA_VSTART = 4'd4;
  localparam logic [ADDR_W-1:0] RA_VEND   = 4'd5;
  localparam logic [ADDR_W-1:0] RA_POL    = 4'd6;
  localparam logic [ADDR_W-1:0] RA_UFLOW  = 4'd7;
  localparam logic [ADDR_W-1:0] RA_BORDER = 4'd8;
  localparam logic [ADDR_W-1:0] RA_RUN    = 4'd9;
  localparam logic [ADDR_W-1:0] RA_CNTEN  = 4'd10;

  localparam logic [COL_W-1:0] UFLOW_RST = COL_W'(8'hff);
endpackage

// File: rtl/ftg_regs.sv
module ftg_regs
  import ftg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output timing_t           live,
  output logic [1:0]        pol,
  output logic              run_req,
  output logic [1:0]        cnt_en,
  output logic [COL_W-1:0]  uflow,
  output logic [COL_W-1:0]  border
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= '0;
      pol     <= '0;
      run_req <= 1'b0;
      cnt_en  <= '0;
      uflow   <= UFLOW_RST;
      border  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_HCTL: begin
          live.hper <= wr_data[H_W-1:0];
          live.hpw  <= wr_data[2*H_W-1:H_W];
        end
        RA_HWIN: begin
          live.hstart <= wr_data[H_W-1:0];
          live.hend   <= wr_data[2*H_W-1:H_W];
        end
        RA_VPER:   live.vper   <= wr_data[F_W-1:0];
        RA_VLEN:   live.vlen   <= wr_data[F_W-1:0];
        RA_VSTART: live.vstart <= wr_data[F_W-1:0];
        RA_VEND:   live.vend   <= wr_data[F_W-1:0];
        RA_POL:    pol         <= wr_data[1:0];
        RA_UFLOW:  uflow       <= wr_data[COL_W-1:0];
        RA_BORDER: border      <= wr_data[COL_W-1:0];
        RA_RUN:    run_req     <= wr_data[0];
        RA_CNTEN:  cnt_en      <= wr_data[1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ftg_scan.sv
module ftg_scan
  import ftg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           run_req,
  input  timing_t        live,
  output logic           run,
  output logic [F_W-1:0] p_cnt,
  output logic [H_W-1:0] h_cnt,
  output timing_t        act,
  output logic           frame_last
);
  assign frame_last = run && (p_cnt == act.vper - F_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      p_cnt <= '0;
      h_cnt <= '0;
      act   <= '0;
    end else if (!run) begin
      if (run_req) begin
        run   <= 1'b1;
        p_cnt <= '0;
        h_cnt <= '0;
        act   <= live;
      end
    end else if (frame_last) begin
      p_cnt <= '0;
      h_cnt <= '0;
      if (run_req) act <= live;
      else         run <= 1'b0;
    end else begin
      p_cnt <= p_cnt + F_W'(1);
      h_cnt <= (h_cnt == act.hper - H_W'(1)) ? '0 : h_cnt + H_W'(1);
    end
  end
endmodule

// File: rtl/ftg_out.sv
module ftg_out
  import ftg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [F_W-1:0]   p_cnt,
  input  logic [H_W-1:0]   h_cnt,
  input  timing_t          act,
  input  logic             frame_last,
  input  logic [1:0]       pol,
  input  logic [1:0]       cnt_en,
  input  logic [COL_W-1:0] uflow,
  input  logic [COL_W-1:0] border,
  input  logic             pix_valid,
  input  logic [COL_W-1:0] pix_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [COL_W-1:0] pix_out,
  output logic             vblank,
  output logic [CNT_W-1:0] line_cnt,
  output logic [CNT_W-1:0] frame_cnt
);
  logic hs_on, vs_on, de_on, line_start;

  always_comb begin
    hs_on      = run && (h_cnt < act.hpw);
    vs_on      = run && (p_cnt < act.vlen);
    de_on      = run && (h_cnt >= act.hstart) && (h_cnt <= act.hend)
                     && (p_cnt >= act.vstart) && (p_cnt <= act.vend);
    line_start = run && (h_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      de        <= 1'b0;
      pix_out   <= '0;
      vblank    <= 1'b0;
      line_cnt  <= '0;
      frame_cnt <= '0;
    end else begin
      hsync  <= hs_on ^ pol[0];
      vsync  <= vs_on ^ pol[1];
      de     <= de_on;
      vblank <= frame_last;
      if (de_on) pix_out <= pix_valid ? pix_data : uflow;
      else       pix_out <= border;
      if (line_start && cnt_en[0])
        line_cnt <= (p_cnt == '0) ? '0 : line_cnt + CNT_W'(1);
      if (frame_last && cnt_en[1])
        frame_cnt <= frame_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import ftg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pix_valid,
  input  logic [COL_W-1:0]  pix_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [COL_W-1:0]  pix_out,
  output logic              vblank,
  output logic [CNT_W-1:0]  line_cnt,
  output logic [CNT_W-1:0]  frame_cnt
);
  timing_t          live, act;
  logic [1:0]       pol, cnt_en;
  logic             run_req, run, frame_last;
  logic [COL_W-1:0] uflow, border;
  logic [F_W-1:0]   p_cnt;
  logic [H_W-1:0]   h_cnt;

  ftg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live(live), .pol(pol), .run_req(run_req), .cnt_en(cnt_en),
    .uflow(uflow), .border(border)
  );

  ftg_scan u_scan (
    .clk(clk), .rst(rst), .run_req(run_req), .live(live),
    .run(run), .p_cnt(p_cnt), .h_cnt(h_cnt), .act(act), .frame_last(frame_last)
  );

  ftg_out u_out (
    .clk(clk), .rst(rst), .run(run), .p_cnt(p_cnt), .h_cnt(h_cnt), .act(act),
    .frame_last(frame_last), .pol(pol), .cnt_en(cnt_en), .uflow(uflow),
    .border(border), .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .vblank(vblank),
    .line_cnt(line_cnt), .frame_cnt(frame_cnt)
  );
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker
  import ftg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             de,
  input logic             vblank,
  input logic             pix_valid,
  input logic [COL_W-1:0] pix_out,
  input logic [COL_W-1:0] uflow,
  input logic [1:0]       cnt_en,
  input logic [CNT_W-1:0] frame_cnt
);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!de && !vblank));

  a_r7_vblank_run: assert property (@(posedge clk) disable iff (rst)
    vblank |-> $past(run));

  a_r5_uflow_fill: assert property (@(posedge clk) disable iff (rst)
    (de && !$past(pix_valid)) |-> (pix_out == $past(uflow)));

  a_r10_frame_step: assert property (@(posedge clk) disable iff (rst)
    (frame_cnt != $past(frame_cnt)) |->
      (vblank && frame_cnt == $past(frame_cnt) + CNT_W'(1)));

  a_r10_frame_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cnt_en[1]) |-> $stable(frame_cnt));
endmodule

bind frame_timing_gen ftg_checker u_chk (
  .clk(clk), .rst(rst), .run(run), .de(de), .vblank(vblank),
  .pix_valid(pix_valid), .pix_out(pix_out), .uflow(uflow),
  .cnt_en(cnt_en), .frame_cnt(frame_cnt)
);

// File: tb/tb_frame_timing_gen.sv
module tb_frame_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        hsync, vsync, de, vblank;
  logic [23:0] pix_out;
  logic [15:0] line_cnt, frame_cnt;

  int tests = 0;
  int fails = 0;

  int c_hper[2], c_hpw[2], c_hst[2], c_hen[2], c_vper[2], c_vlen[2];
  int c_vst[2], c_ven[2], c_hdisp[2], c_vdisp[2], c_vtot[2];
  int hp = 0, vp = 0, pv = 0, lc_on = 1;
  logic [23:0] pd = '0, uf = 24'h0000ff, bd = '0;

  frame_timing_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_out(pix_out), .vblank(vblank), .line_cnt(line_cnt),
    .frame_cnt(frame_cnt)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic calc(input int c, input int htot, input int hdisp, input int hss,
                      input int hse, input int vtot, input int vdisp, input int vss,
                      input int vse);
    c_hper[c] = htot;
    c_hpw[c]  = hse - hss;
    c_hst[c]  = htot - hss;
    c_hen[c]  = htot - (hss - hdisp) - 1;
    c_vper[c] = vtot * htot;
    c_vlen[c] = (vse - vss) * htot;
    c_vst[c]  = (vtot - vss) * htot;
    c_ven[c]  = vtot * htot - (vss - vdisp) * htot - 1;
    c_hdisp[c] = hdisp; c_vdisp[c] = vdisp; c_vtot[c] = vtot;
  endtask

  task automatic push(input int c);
    wr(0, (c_hpw[c] << 16) | c_hper[c]);
    wr(1, (c_hen[c] << 16) | c_hst[c]);
    wr(2, c_vper[c]);
    wr(3, c_vlen[c]);
    wr(4, c_vst[c]);
    wr(5, c_ven[c]);
  endtask

  task automatic wait_vblank();
    do @(negedge clk); while (vblank !== 1'b1);
  endtask

  task automatic check_frame(input int c, input string nm);
    int de_n = 0, hs_n = 0, vs_n = 0;
    int bad_h = 0, bad_v = 0, bad_de = 0, bad_pix = 0, bad_line = 0, bad_vb = 0;
    logic [15:0] fc0 = '0;
    wait_vblank();
    for (int p = 0; p < c_vper[c]; p++) begin
      int h;
      bit ehs, evs, ede, evb;
      logic [23:0] epix;
      @(negedge clk);
      h   = p % c_hper[c];
      ehs = (h < c_hpw[c]);
      evs = (p < c_vlen[c]);
      ede = (h >= c_hst[c]) && (h <= c_hen[c]) && (p >= c_vst[c]) && (p <= c_ven[c]);
      evb = (p == c_vper[c] - 1);
      epix = ede ? (pv != 0 ? pd : uf) : bd;
      if (hsync === 1'(ehs ^ hp[0])) begin if (ehs) hs_n++; end else bad_h++;
      if (vsync === 1'(evs ^ vp[0])) begin if (evs) vs_n++; end else bad_v++;
      if (de === ede) begin if (ede) de_n++; end else bad_de++;
      if (pix_out !== epix) bad_pix++;
      if (vblank !== evb) bad_vb++;
      if (lc_on != 0 && line_cnt !== 16'(p / c_hper[c])) bad_line++;
      if (p == 0) fc0 = frame_cnt;
    end
    check(bad_h == 0, {"R1 hsync per-pixel ", nm}, bad_h, 0);
    check(hs_n == c_hpw[c] * c_vtot[c], {"R1 hsync total ", nm}, hs_n, c_hpw[c] * c_vtot[c]);
    check(bad_v == 0, {"R2 vsync per-pixel ", nm}, bad_v, 0);
    check(vs_n == c_vlen[c], {"R2 vsync total ", nm}, vs_n, c_vlen[c]);
    check(bad_de == 0, {"R3 de per-pixel ", nm}, bad_de, 0);
    check(de_n == c_hdisp[c] * c_vdisp[c], {"R3 de total ", nm}, de_n, c_hdisp[c] * c_vdisp[c]);
    check(bad_pix == 0, {"R5 pixel output ", nm}, bad_pix, 0);
    check(bad_vb == 0, {"R7 vblank pulse ", nm}, bad_vb, 0);
    if (lc_on != 0) check(bad_line == 0, {"R9 line counter ", nm}, bad_line, 0);
    check(frame_cnt == fc0 + 16'd1, {"R10 frame step ", nm}, int'(frame_cnt), int'(fc0) + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    logic [15:0] lc_s, fc_s;
    int bad;
    calc(0, 10, 6, 7, 9, 6, 3, 4, 5);
    calc(1, 8, 4, 5, 6, 5, 2, 3, 4);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(hsync === 1'b0 && vsync === 1'b0, "R11 syncs low", int'({hsync, vsync}), 0);
    check(de === 1'b0 && vblank === 1'b0, "R11 de/vblank low", int'({de, vblank}), 0);
    check(line_cnt === 16'd0 && frame_cnt === 16'd0, "R11 counters", int'(frame_cnt), 0);
    check(pix_out === 24'd0, "R11 pix_out", int'(pix_out), 0);

    // R1 R2 R3 R5 R6: mode A with valid data
    push(0);
    wr(10, 3);
    wr(9, 1);
    pv = 1; pd = 24'h00abcd; pix_valid = 1'b1; pix_data = pd;
    check_frame(0, "modeA data");

    // R5 underflow with default fill, then reprogrammed fill and border
    pv = 0; pix_valid = 1'b0;
    check_frame(0, "modeA uflow default");
    wr(7, 24'h123456); uf = 24'h123456;
    wr(8, 24'h0f0f0f); bd = 24'h0f0f0f;
    check_frame(0, "modeA uflow prog");

    // R8: mode B written mid-frame; current frame stays mode A
    fork
      check_frame(0, "R8 shadow holds A");
      begin
        wait_vblank();
        repeat (3) @(negedge clk);
        push(1);
      end
    join
    check_frame(1, "R8 modeB applied");

    // R4 polarity inversion
    wr(6, 3); hp = 1; vp = 1;
    check_frame(1, "R4 active-low");

    // R9 R10 counters held when disabled
    wr(10, 0); lc_on = 0;
    wait_vblank();
    lc_s = line_cnt; fc_s = frame_cnt;
    repeat (2 * c_vper[1]) @(negedge clk);
    check(line_cnt === lc_s, "R9 line hold", int'(line_cnt), int'(lc_s));
    check(frame_cnt === fc_s, "R10 frame hold", int'(frame_cnt), int'(fc_s));
    wr(10, 3); lc_on = 1;

    // R6 stop mid-frame: frame completes, then idle
    wait_vblank();
    k = 0;
    fork
      begin
        do begin @(negedge clk); k++; end while (vblank !== 1'b1);
      end
      begin
        repeat (3) @(negedge clk);
        wr(9, 0);
      end
    join
    check(k == c_vper[1], "R6 stop finishes frame", k, c_vper[1]);
    bad = 0;
    for (int i = 0; i < 3 * c_vper[1]; i++) begin
      @(negedge clk);
      if (de !== 1'b0 || vblank !== 1'b0 || hsync !== 1'(hp) || vsync !== 1'(vp)
          || pix_out !== bd) bad++;
    end
    check(bad == 0, "R6 idle outputs", bad, 0);

    // R6 R8 restart from idle with mode A and normal polarity
    push(0);
    wr(6, 0); hp = 0; vp = 0;
    pv = 1; pix_valid = 1'b1; pd = 24'hfedcba; pix_data = pd;
    wr(9, 1);
    check_frame(0, "R6 restart modeA");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule